// File: doc/BRIEF.md
# Touch and Button SPI Polling Sequencer

This block is the host side of a serial link to a touch-panel and button controller. While `poll_en` is high it runs back-to-back SPI frames and cycles through four read commands (buttons, battery, X, Y). Every frame drops a select line, waits a long fixed setup time before the first clock edge, and then exchanges one 10-bit word in SPI mode 0. The serial clock runs at the system clock divided by a parameter, 512 by default.

The peripheral answers each command one frame late. The word that comes back during a frame therefore belongs to the command sent in the frame before it. The sequencer holds the identity of that earlier command, writes each returned word into the matching result register and pulses one strobe bit. When polling stops, one extra frame collects the last outstanding answer. A power-down request made while the block is idle first waits through a long guard interval and then sends the power-down command in a frame of its own. A separate reset output to the peripheral is held high at all times outside reset.

Top module: `spi_poll_seq`

## Requirements
- R1: During reset, `cs_n` is 1, `sck` is 0, `mosi` is 0, `periph_rst_n` is 0, `busy` is 0, `res_stb` is 0 and all four result outputs are 0.
- R2: Each frame has exactly WORD_W (10) rising `sck` edges while `cs_n` is low. `sck` is low whenever `cs_n` is high (mode 0, idle low). `mosi` carries the command MSB first, valid at each rising edge. `miso` is captured on each rising edge, MSB first.
- R3: Inside a frame, rising `sck` edges are CLK_DIV system cycles apart, and each high phase lasts CLK_DIV/2 cycles.
- R4: The first rising `sck` edge of a frame comes exactly SETUP_SCK*CLK_DIV + CLK_DIV/2 cycles after `cs_n` falls.
- R5: Between two frames of one busy stretch, `cs_n` stays high for exactly GAP_SCK*CLK_DIV cycles.
- R6: Poll frames send 0x200, 0x080, 0x040, 0x000 in that repeating order. Every stretch that starts from idle begins with 0x200.
- R7: The word received in frame j is written to the register of the command of frame j-1, with a one-cycle pulse on `res_stb` bit 0 (0x200 → `btn_val`), bit 1 (0x080 → `bat_val`), bit 2 (0x040 → `x_val`) or bit 3 (0x000 → `y_val`). At most one bit is high at a time. The word of the first frame after idle, and of any frame that follows a flush or power-down frame, is discarded.
- R8: If `poll_en` is low when the gap after a poll frame ends, exactly one flush frame sending 0x200 follows. Its own answer is dropped, and the block then returns to idle with `busy` low. A stretch of N poll frames therefore gives N+1 frames and N strobes.
- R9: A one-cycle `pd_req` in idle keeps `cs_n` high for GUARD_SCK*CLK_DIV cycles after the edge that samples it. One frame sending 0x100 follows, with no strobe, and then the block is idle again.
- R10: `pd_req` is ignored while `busy` is high, so no 0x100 frame results from it.
- R11: `periph_rst_n` is 1 from the first clock edge after reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_en | input | 1 | Keep polling while high |
| pd_req | input | 1 | Power-down request, taken only in idle |
| miso | input | 1 | Serial data from the peripheral |
| cs_n | output | 1 | Active-low peripheral select |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the peripheral |
| periph_rst_n | output | 1 | Peripheral reset, high in operation |
| busy | output | 1 | Sequencer is not idle |
| btn_val | output | WORD_W | Last button word |
| bat_val | output | WORD_W | Last battery word |
| x_val | output | WORD_W | Last X coordinate |
| y_val | output | WORD_W | Last Y coordinate |
| res_stb | output | 4 | One-cycle write strobe per result register |

## Verification
The hardest case to reach is the tail of the response pipeline. This is the moment when `poll_en` falls after a chosen number of frames, so that the flush frame must deliver the last outstanding answer to the right register while its own answer is thrown away. The bench runs a table of stretch lengths: one frame, part of a sweep, a whole sweep and more than one sweep. For each length it drops `poll_en` as soon as the last wanted frame begins. A serial peripheral model answers each frame with a value derived from the previous command and a frame number, so a word filed in the wrong register cannot match. A power-down pulse is also issued in the middle of a stretch and then again from idle.

// File: rtl/spi_poll_seq.sv
module spi_poll_seq #(
  parameter int CLK_DIV   = 512,
  parameter int SETUP_SCK = 64,
  parameter int GAP_SCK   = 2,
  parameter int GUARD_SCK = 256,
  parameter int WORD_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_en,
  input  logic              pd_req,
  input  logic              miso,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  output logic              periph_rst_n,
  output logic              busy,
  output logic [WORD_W-1:0] btn_val,
  output logic [WORD_W-1:0] bat_val,
  output logic [WORD_W-1:0] x_val,
  output logic [WORD_W-1:0] y_val,
  output logic [3:0]        res_stb
);
  localparam int HALF      = CLK_DIV / 2;
  localparam int SETUP_CYC = SETUP_SCK * CLK_DIV;
  localparam int GAP_CYC   = GAP_SCK * CLK_DIV;
  localparam int GUARD_CYC = GUARD_SCK * CLK_DIV;
  localparam int MAX_CYC   = (GUARD_CYC > SETUP_CYC) ? GUARD_CYC : SETUP_CYC;
  localparam int CW        = $clog2(MAX_CYC) + 1;
  localparam int BW        = $clog2(WORD_W) + 1;

  localparam logic [CW-1:0] HALF_C   = CW'(HALF);
  localparam logic [CW-1:0] HALF_L   = CW'(HALF - 1);
  localparam logic [CW-1:0] BIT_L    = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] SETUP_L  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] GAP_L    = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] GUARD_L  = CW'(GUARD_CYC - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  localparam logic [WORD_W-1:0] CMD_PD    = WORD_W'(10'h100);
  localparam logic [WORD_W-1:0] CMD_FLUSH = WORD_W'(10'h200);

  typedef enum logic [2:0] {S_IDLE, S_GUARD, S_SETUP, S_SHIFT, S_GAP} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bcnt;
  logic [WORD_W-1:0] tx, rx;
  logic [1:0]        nidx, cidx, pidx;
  logic              cnorm, pend, prst;
  logic [WORD_W-1:0] res [4];
  logic [3:0]        stb;

  function automatic logic [WORD_W-1:0] cmd_of(input logic [1:0] i);
    case (i)
      2'd0:    return WORD_W'(10'h200);
      2'd1:    return WORD_W'(10'h080);
      2'd2:    return WORD_W'(10'h040);
      default: return WORD_W'(10'h000);
    endcase
  endfunction

  assign cs_n         = !(st == S_SETUP || st == S_SHIFT);
  assign sck          = (st == S_SHIFT) && (cnt >= HALF_C);
  assign mosi         = tx[WORD_W-1];
  assign busy         = (st != S_IDLE);
  assign periph_rst_n = prst;
  assign res_stb      = stb;
  assign btn_val      = res[0];
  assign bat_val      = res[1];
  assign x_val        = res[2];
  assign y_val        = res[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      bcnt  <= '0;
      tx    <= '0;
      rx    <= '0;
      nidx  <= '0;
      cidx  <= '0;
      pidx  <= '0;
      cnorm <= 1'b0;
      pend  <= 1'b0;
      prst  <= 1'b0;
      stb   <= '0;
      for (int i = 0; i < 4; i++) res[i] <= '0;
    end else begin
      prst <= 1'b1;
      stb  <= '0;
      case (st)
        S_IDLE:
          if (pd_req) begin
            st  <= S_GUARD;
            cnt <= '0;
          end else if (poll_en) begin
            st    <= S_SETUP;
            cnt   <= '0;
            tx    <= cmd_of(2'd0);
            cidx  <= 2'd0;
            nidx  <= 2'd1;
            cnorm <= 1'b1;
          end
        S_GUARD:
          if (cnt == GUARD_L) begin
            st    <= S_SETUP;
            cnt   <= '0;
            tx    <= CMD_PD;
            cnorm <= 1'b0;
          end else cnt <= cnt + 1'b1;
        S_SETUP:
          if (cnt == SETUP_L) begin
            st   <= S_SHIFT;
            cnt  <= '0;
            bcnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_SHIFT: begin
          if (cnt == HALF_L) rx <= {rx[WORD_W-2:0], miso};
          if (cnt == BIT_L) begin
            cnt <= '0;
            tx  <= {tx[WORD_W-2:0], 1'b0};
            if (bcnt == LAST_BIT) begin
              st <= S_GAP;
              if (pend) begin
                res[pidx] <= rx;
                stb[pidx] <= 1'b1;
              end
              pend <= cnorm;
              pidx <= cidx;
            end else bcnt <= bcnt + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_GAP:
          if (cnt == GAP_L) begin
            cnt <= '0;
            if (poll_en) begin
              st    <= S_SETUP;
              tx    <= cmd_of(nidx);
              cidx  <= nidx;
              nidx  <= nidx + 2'd1;
              cnorm <= 1'b1;
            end else if (pend) begin
              st    <= S_SETUP;
              tx    <= CMD_FLUSH;
              nidx  <= '0;
              cnorm <= 1'b0;
            end else begin
              st   <= S_IDLE;
              nidx <= '0;
            end
          end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_poll_seq_chk.sv
module spi_poll_seq_chk #(
  parameter int GAP_CYC = 1024
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       periph_rst_n,
  input logic [3:0] res_stb
);
  localparam int HW = $clog2(GAP_CYC + 1) + 1;
  localparam logic [HW-1:0] GAP_V = HW'(GAP_CYC);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_cnt <= GAP_V;
    else if (cs_n) hi_cnt <= (hi_cnt >= GAP_V) ? hi_cnt : hi_cnt + 1'b1;
    else           hi_cnt <= '0;
  end

  AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R2
  AST_SELECT_LEADS: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> !sck); // R4
  AST_GAP_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> (hi_cnt >= GAP_V)); // R5
  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(res_stb)); // R7
  AST_STB_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n) (res_stb != 4'b0) |-> (cs_n && !sck)); // R7
  AST_PRST_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> periph_rst_n); // R11
endmodule

bind spi_poll_seq spi_poll_seq_chk #(.GAP_CYC(GAP_SCK * CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
  .periph_rst_n(periph_rst_n), .res_stb(res_stb)
);

// File: tb/spi_poll_seq_bench.sv
module spi_poll_seq_bench;
  localparam int DIV = 8, SET = 4, GAP = 2, GRD = 6, W = 10;
  localparam int HALF = DIV / 2, SET_C = SET * DIV, GAP_C = GAP * DIV, GRD_C = GRD * DIV;
  localparam int RUNS [6] = '{1, 2, 3, 4, 5, 9};

  logic clk = 1'b0, rst_n = 1'b0, poll_en = 1'b0, pd_req = 1'b0, miso = 1'b0;
  logic cs_n, sck, mosi, periph_rst_n, busy;
  logic [W-1:0] btn_val, bat_val, x_val, y_val;
  logic [3:0] res_stb;

  spi_poll_seq #(.CLK_DIV(DIV), .SETUP_SCK(SET), .GAP_SCK(GAP), .GUARD_SCK(GRD), .WORD_W(W)) u_spi_poll_seq (
    .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .pd_req(pd_req), .miso(miso),
    .cs_n(cs_n), .sck(sck), .mosi(mosi), .periph_rst_n(periph_rst_n), .busy(busy),
    .btn_val(btn_val), .bat_val(bat_val), .x_val(x_val), .y_val(y_val), .res_stb(res_stb));

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] seq_cmd(input int i);
    case (i % 4)
      0:       return 10'h200;
      1:       return 10'h080;
      2:       return 10'h040;
      default: return 10'h000;
    endcase
  endfunction

  function automatic int idx_of(input logic [W-1:0] c);
    case (c)
      10'h200: return 0;
      10'h080: return 1;
      10'h040: return 2;
      10'h000: return 3;
      default: return 7;
    endcase
  endfunction

  function automatic int val_of(input int k);
    case (k)
      0:       return int'(btn_val);
      1:       return int'(bat_val);
      2:       return int'(x_val);
      default: return int'(y_val);
    endcase
  endfunction

  int frame_cnt = 0, scn_base = 0, exp_n = 0, pd_frames = 0, stb_cnt = 0, fno = 0;
  bit pd_expect = 1'b0;
  logic [W-1:0] scmd = '0, sh = '0, cur_resp = '0, cur_cmd = 10'h3FF;
  logic [W-1:0] nxt_resp = 10'h155, nxt_cmd = 10'h3FF;
  logic [W-1:0] last_val [4] = '{default: '0};
  int pre_cnt = 0, rises = 0, since = 0, hi = 0, gap_cnt = 0;
  bit saw_idle = 1'b1, p_cs = 1'b1, p_sck = 1'b0;

  always @(posedge sck) scmd = {scmd[W-2:0], mosi};
  always @(negedge sck) if (!cs_n) begin
    sh   = {sh[W-2:0], 1'b0};
    miso = sh[W-1];
  end

  always @(negedge clk) if (rst_n) begin
    if (!cs_n && p_cs) begin
      frame_cnt++;
      if (!saw_idle) chk_eq("R5 select high gap", gap_cnt, GAP_C);
      pre_cnt = 0; rises = 0; since = 0;
      cur_resp = nxt_resp; cur_cmd = nxt_cmd;
      sh = nxt_resp; miso = sh[W-1];
    end
    if (cs_n && !p_cs) begin
      int fi;
      logic [W-1:0] ec;
      chk_eq("R2 rising edges per frame", rises, W);
      fi = frame_cnt - scn_base - 1;
      ec = pd_expect ? 10'h100 : ((fi < exp_n) ? seq_cmd(fi) : 10'h200);
      chk_eq((fi < exp_n || pd_expect) ? "R6 command word" : "R8 flush command", int'(scmd), int'(ec));
      if (scmd == 10'h100) pd_frames++;
      fno++;
      nxt_cmd  = scmd;
      nxt_resp = (scmd ^ 10'h3A5) + 10'(fno * 7);
      gap_cnt = 0; saw_idle = 1'b0;
    end
    if (!cs_n && sck && !p_sck) begin
      rises++;
      if (rises == 1) chk_eq("R4 select-to-first-edge", pre_cnt, SET_C + HALF);
      else chk_eq("R3 edge spacing", since, DIV);
      since = 0;
    end
    if (!sck && p_sck) begin
      chk_eq("R3 high time", hi, HALF);
      hi = 0;
    end
    if (sck) hi++;
    if (!cs_n) begin
      since++;
      if (!sck && rises == 0) pre_cnt++;
    end else begin
      gap_cnt++;
      if (!busy) saw_idle = 1'b1;
    end
    if (res_stb != 4'b0) begin
      int k;
      stb_cnt++;
      k = idx_of(cur_cmd);
      chk_eq("R7 strobe one-hot", $countones(res_stb), 1);
      chk_eq("R7 strobe register", int'(res_stb), (k < 4) ? (1 << k) : 0);
      if (k < 4) begin
        chk_eq("R7 stored value", val_of(k), int'(cur_resp));
        last_val[k] = cur_resp;
      end
    end
    p_cs = cs_n; p_sck = sck;
  end

  task automatic run_scn(input int n, input bit pulse_pd);
    int s0, p0, f0;
    s0 = stb_cnt; p0 = pd_frames; f0 = frame_cnt;
    scn_base = frame_cnt; exp_n = n; pd_expect = 1'b0;
    @(negedge clk) poll_en = 1'b1;
    while (frame_cnt < f0 + 1) @(negedge clk);
    if (pulse_pd) begin
      pd_req = 1'b1;
      @(negedge clk) pd_req = 1'b0;
    end
    while (frame_cnt < f0 + n) @(negedge clk);
    poll_en = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk_eq("R8 frames in run", frame_cnt - f0, n + 1);
    chk_eq("R8 results delivered", stb_cnt - s0, n);
    chk_eq("R8 idle after flush", int'(busy), 0);
    if (pulse_pd) chk_eq("R10 power-down ignored while busy", pd_frames - p0, 0);
    for (int k = 0; k < 4; k++) chk_eq("R7 held result", val_of(k), int'(last_val[k]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_eq("R1 cs_n in reset", int'(cs_n), 1);
    chk_eq("R1 sck/mosi in reset", int'({sck, mosi}), 0);
    chk_eq("R1 periph_rst_n in reset", int'(periph_rst_n), 0);
    chk_eq("R1 busy/strobe in reset", int'({busy, res_stb}), 0);
    chk_eq("R1 results in reset", int'(btn_val | bat_val | x_val | y_val), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R11 periph_rst_n after reset", int'(periph_rst_n), 1);

    for (int i = 0; i < 6; i++) run_scn(RUNS[i], 1'b0);

    begin
      int p0, s0, f0, n;
      p0 = pd_frames; s0 = stb_cnt; f0 = frame_cnt;
      scn_base = frame_cnt; pd_expect = 1'b1;
      pd_req = 1'b1;
      @(negedge clk) pd_req = 1'b0;
      n = 0;
      while (cs_n && n < 10000) begin
        n++;
        @(negedge clk);
      end
      chk_eq("R9 guard length", n, GRD_C);
      while (busy) @(negedge clk);
      @(negedge clk);
      chk_eq("R9 power-down frame sent", pd_frames - p0, 1);
      chk_eq("R9 single frame", frame_cnt - f0, 1);
      chk_eq("R9 no strobe", stb_cnt - s0, 0);
      chk_eq("R9 idle after power-down", int'(busy), 0);
      pd_expect = 1'b0;
    end

    run_scn(3, 1'b1);
    run_scn(2, 1'b0);
    chk_eq("R11 periph_rst_n held", int'(periph_rst_n), 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule